// File: doc/BRIEF.md
# Oscillation Stabilization Wait Timer

This block keeps the system clock gated off from the processor until a crystal or ceramic resonator has had time to settle. Software picks one of four power-of-two wait lengths through a 2-bit field in an 8-bit register written over a plain byte bus. When STOP mode ends, the block counts resonator cycles and raises a registered clock-ready level once the chosen number of cycles has been seen.

The wait is only inserted when the crystal source is selected. With the internal high-speed oscillator or an external clock feeding the system, ready comes back at once. The wait that follows power-up or reset uses a static configuration code instead of the register. That code is the reason the register can stay unreset. Counting advances only on cycles where the oscillator is reported live, so the dead time before the first resonator edges adds nothing to the count. A release caused by reset and a release caused by an interrupt get the same treatment.

Top module: `osw_timer`

## Requirements
- R1: Register field bits [1:0] select the wait length. 2'b00 gives 2^EXP0 counted cycles, 2'b01 gives 2^EXP1, 2'b10 gives 2^EXP2 and 2'b11 gives 2^EXP3. The defaults are 10, 12, 15 and 17. On a crystal release, clk_ready rises on exactly the N-th counted clock edge after the edge that takes stop_release.
- R2: src_sel encodes the source: 2'b00 is crystal, 2'b01 is internal oscillator, and 2'b10 or 2'b11 is external clock. For any non-crystal source, clk_ready rises on the same edge that takes stop_release.
- R3: While rst_n is low, clk_ready is 0. After reset the wait length comes from reset_code (same encoding as R1), not from the register. With a non-crystal source, clk_ready rises on the first edge after reset is released.
- R4: A clock edge only counts toward the wait when osc_live is 1. While osc_live is 0 the count holds and clk_ready stays 0.
- R5: rd_data returns the 2-bit field in bits [1:0] and zero in bits [7:2]. Write data in bits [7:2] is ignored.
- R6: stop_enter, while the block is counting or ready, drops clk_ready and clears the count on the next edge. Every release starts its count from zero.
- R7: The wait length is captured at release. A register write during a count does not change that count. A write in the same cycle as stop_release takes effect only at the next release.
- R8: Once set, clk_ready stays 1 until stop_enter or reset.
- R9: stop_release is ignored while counting or ready. stop_enter is ignored while already stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock that is counted |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Register write data |
| rd_data | output | DATA_W | Register read data |
| src_sel | input | 2 | System clock source select |
| reset_code | input | 2 | Static wait code used after reset |
| osc_live | input | 1 | Oscillator is producing edges this cycle |
| stop_enter | input | 1 | STOP mode entry pulse |
| stop_release | input | 1 | STOP mode release pulse (reset or interrupt) |
| clk_ready | output | 1 | Registered clock-ready level |

## Verification
Two things can land in the same clock cycle: a register write to the select field and the STOP release that captures the wait length. The bench provokes this by driving wr_en and stop_release together. It then judges the result by measuring the wait length, which must match the old field value. A later release must use the new value. Related collisions are also driven: a write in the middle of a count, a release while already counting, and stop_enter while a count is running. Each is judged by the number of live edges counted before clk_ready rises.

// File: rtl/osw_pkg.sv
`timescale 1ns/1ps
package osw_pkg;
   typedef enum logic [1:0] {
      ST_STOP  = 2'd0,
      ST_COUNT = 2'd1,
      ST_READY = 2'd2
   } osw_state_e;

   localparam logic [1:0] SRC_XTAL = 2'b00;
   localparam int         SEL_W    = 2;
   localparam int         N_CODES  = 4;
endpackage

// File: rtl/osw_sel_reg.sv
`timescale 1ns/1ps
module osw_sel_reg #(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [SEL_W-1:0]  sel_q,
   output logic [DATA_W-1:0] rd_data
);
   // Contents are undefined until software writes the field: no reset.
   always_ff @(posedge clk) begin
      if (wr_en) sel_q <= wr_data[SEL_W-1:0];
   end

   assign rd_data = {{(DATA_W-SEL_W){1'b0}}, sel_q};
endmodule

// File: rtl/osw_term_dec.sv
`timescale 1ns/1ps
module osw_term_dec
   import osw_pkg::*;
#(
   parameter int CNT_W = 17,
   parameter int EXP0  = 10,
   parameter int EXP1  = 12,
   parameter int EXP2  = 15,
   parameter int EXP3  = 17
) (
   input  logic [SEL_W-1:0] code,
   output logic [CNT_W-1:0] term
);
   logic [N_CODES-1:0][CNT_W-1:0] tab;

   for (genvar i = 0; i < N_CODES; i++) begin : g_tab
      localparam int E = (i == 0) ? EXP0 : (i == 1) ? EXP1 :
                         (i == 2) ? EXP2 : EXP3;
      // terminal count is 2^E - 1
      assign tab[i] = {CNT_W{1'b1}} >> (CNT_W - E);
   end

   assign term = tab[code];
endmodule

// File: rtl/osw_counter.sv
`timescale 1ns/1ps
module osw_counter #(
   parameter int CNT_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [CNT_W-1:0] term,
   output logic [CNT_W-1:0] cnt,
   output logic             hit
);
   assign hit = en && (cnt == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clr)        cnt <= '0;
      else if (en && !hit) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/osw_timer.sv
`timescale 1ns/1ps
module osw_timer
   import osw_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int EXP0   = 10,
   parameter int EXP1   = 12,
   parameter int EXP2   = 15,
   parameter int EXP3   = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [1:0]        src_sel,
   input  logic [1:0]        reset_code,
   input  logic              osc_live,
   input  logic              stop_enter,
   input  logic              stop_release,
   output logic              clk_ready
);
   localparam int CNT_W = EXP3;

   initial begin
      assert (EXP0 > 0 && EXP0 < EXP1 && EXP1 < EXP2 && EXP2 < EXP3)
         else $error("osw_timer: exponents must be positive and increasing");
      assert (DATA_W >= SEL_W)
         else $error("osw_timer: DATA_W narrower than select field");
   end

   osw_state_e       state;
   logic [SEL_W-1:0] sel_q;
   logic [SEL_W-1:0] code_q;
   logic [CNT_W-1:0] term;
   logic [CNT_W-1:0] cnt;
   logic             hit;
   logic             is_xtal;
   logic             cnt_en;
   logic             cnt_clr;
   logic             ready_q;

   osw_sel_reg #(.DATA_W(DATA_W), .SEL_W(SEL_W)) i_sel_reg (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .sel_q   (sel_q),
      .rd_data (rd_data)
   );

   osw_term_dec #(
      .CNT_W(CNT_W), .EXP0(EXP0), .EXP1(EXP1), .EXP2(EXP2), .EXP3(EXP3)
   ) i_term_dec (
      .code (code_q),
      .term (term)
   );

   assign is_xtal = (src_sel == SRC_XTAL);
   assign cnt_en  = (state == ST_COUNT) && is_xtal && osc_live && !stop_enter;
   assign cnt_clr = (state == ST_STOP) || stop_enter;

   osw_counter #(.CNT_W(CNT_W)) i_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .en    (cnt_en),
      .term  (term),
      .cnt   (cnt),
      .hit   (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_COUNT;
         code_q  <= reset_code;
         ready_q <= 1'b0;
      end else begin
         unique case (state)
            ST_COUNT: begin
               if (stop_enter) begin
                  state   <= ST_STOP;
                  ready_q <= 1'b0;
               end else if (!is_xtal || hit) begin
                  state   <= ST_READY;
                  ready_q <= 1'b1;
               end
            end
            ST_STOP: begin
               if (stop_release) begin
                  code_q <= sel_q;
                  if (!is_xtal) begin
                     state   <= ST_READY;
                     ready_q <= 1'b1;
                  end else begin
                     state <= ST_COUNT;
                  end
               end
            end
            ST_READY: begin
               if (stop_enter) begin
                  state   <= ST_STOP;
                  ready_q <= 1'b0;
               end
            end
            default: begin
               state   <= ST_STOP;
               ready_q <= 1'b0;
            end
         endcase
      end
   end

   assign clk_ready = ready_q;
endmodule

// File: rtl/osw_checker.sv
`timescale 1ns/1ps
module osw_checker
   import osw_pkg::*;
#(
   parameter int CNT_W = 17
) (
   input logic             clk,
   input logic             rst_n,
   input logic             stop_enter,
   input logic             stop_release,
   input logic [1:0]       src_sel,
   input logic             osc_live,
   input logic             clk_ready,
   input osw_state_e       state,
   input logic [CNT_W-1:0] cnt
);
   // R8: level holds until STOP entry
   a_r8_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
      clk_ready && !stop_enter |=> clk_ready);

   // R6: entry from counting or ready drops ready and clears the count
   a_r6_stop_drops: assert property (@(posedge clk) disable iff (!rst_n)
      stop_enter && state != ST_STOP |=> !clk_ready && cnt == '0);

   // R2: bypass for non-crystal sources
   a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_STOP && stop_release && src_sel != SRC_XTAL |=> clk_ready);

   // R4: no oscillator activity, no progress
   a_r4_gate: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_COUNT && !osc_live && !stop_enter && src_sel == SRC_XTAL
      |=> $stable(cnt) && !clk_ready);

   // R9: stopped block stays stopped until released
   a_r9_stay_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_STOP && !stop_release |=> state == ST_STOP && !clk_ready);

   // R1: ready only rises out of a count or a release
   a_r1_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_ready) |-> $past(state) == ST_COUNT ||
                           ($past(state) == ST_STOP && $past(stop_release)));
endmodule

bind osw_timer osw_checker #(.CNT_W(CNT_W)) i_osw_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .stop_enter   (stop_enter),
   .stop_release (stop_release),
   .src_sel      (src_sel),
   .osc_live     (osc_live),
   .clk_ready    (clk_ready),
   .state        (state),
   .cnt          (cnt)
);

// File: tb/test_osw_timer.sv
`timescale 1ns/1ps
module test_osw_timer;
   localparam int E0 = 3;
   localparam int E1 = 4;
   localparam int E2 = 5;
   localparam int E3 = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [1:0] src_sel = 2'b00;
   logic [1:0] reset_code = 2'b10;
   logic       osc_live = 1'b1;
   logic       stop_enter = 1'b0;
   logic       stop_release = 1'b0;
   logic       clk_ready;

   int  checks = 0;
   int  errs   = 0;
   bit  done   = 1'b0;

   osw_timer #(.DATA_W(8), .EXP0(E0), .EXP1(E1), .EXP2(E2), .EXP3(E3)) i_osw_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .src_sel(src_sel), .reset_code(reset_code), .osc_live(osc_live),
      .stop_enter(stop_enter), .stop_release(stop_release), .clk_ready(clk_ready)
   );

   always #10 clk = ~clk;   // 50 MHz

   function automatic int wait_len(logic [1:0] c);
      case (c)
         2'b00:   return 1 << E0;
         2'b01:   return 1 << E1;
         2'b10:   return 1 << E2;
         default: return 1 << E3;
      endcase
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // All tasks start and end at a falling edge.
   task automatic wr(logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_enter();
      stop_enter = 1'b1;
      @(negedge clk);
      stop_enter = 1'b0;
   endtask

   task automatic do_release();
      stop_release = 1'b1;
      @(negedge clk);
      stop_release = 1'b0;
   endtask

   // Counts live edges until clk_ready is seen; randomize toggles osc_live.
   task automatic run_wait(bit randomize, output int live);
      live = 0;
      for (int g = 0; g < 5000; g++) begin
         bit l;
         if (clk_ready) return;
         l = randomize ? (($urandom % 4) != 0) : 1'b1;
         osc_live = l;
         @(negedge clk);
         if (l) live++;
      end
      live = -1;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog all requirements actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      int live;
      int part;
      void'($urandom(32'd4711));

      // R3: reset state and reset-time wait from reset_code (2'b10)
      repeat (3) @(negedge clk);
      chk(clk_ready == 1'b0, "R3 ready low in reset", clk_ready, 0);
      rst_n = 1'b1;
      run_wait(1'b0, live);
      chk(live == wait_len(2'b10), "R3 reset wait uses reset_code", live, wait_len(2'b10));

      // R5: readback of the field, upper bits zero
      wr(8'hFF);
      chk(rd_data == 8'h03, "R5 readback FF", rd_data, 8'h03);
      wr(8'hA6);
      chk(rd_data == 8'h02, "R5 readback A6", rd_data, 8'h02);

      // R9: release while ready is ignored
      do_release();
      chk(clk_ready == 1'b1, "R9 release while ready", clk_ready, 1);
      // R8: hold
      repeat (7) @(negedge clk);
      chk(clk_ready == 1'b1, "R8 ready holds", clk_ready, 1);

      // R1: each code, random osc_live gaps
      for (int c = 0; c < 4; c++) begin
         wr(8'(c));
         do_enter();
         chk(clk_ready == 1'b0, "R6 entry drops ready", clk_ready, 0);
         do_enter();   // R9: second entry while stopped
         repeat (3) @(negedge clk);
         chk(clk_ready == 1'b0, "R9 stays stopped", clk_ready, 0);
         do_release();
         run_wait(1'b1, live);
         chk(live == wait_len(2'(c)), "R1 wait per code", live, wait_len(2'(c)));
      end

      // R4: osc_live low holds the count
      wr(8'h00);
      do_enter();
      do_release();
      osc_live = 1'b0;
      repeat (20) @(negedge clk);
      chk(clk_ready == 1'b0, "R4 no progress without oscillator", clk_ready, 0);
      run_wait(1'b0, live);
      chk(live == wait_len(2'b00), "R4 count resumes", live, wait_len(2'b00));

      // R7: write during count
      do_enter();
      do_release();
      osc_live = 1'b1;
      repeat (3) @(negedge clk);
      wr(8'h03);
      run_wait(1'b0, live);
      part = 4 + live;
      chk(part == wait_len(2'b00), "R7 write mid-count ignored", part, wait_len(2'b00));
      do_enter();
      do_release();
      run_wait(1'b0, live);
      chk(live == wait_len(2'b11), "R7 new code next release", live, wait_len(2'b11));

      // R7: write in the release cycle (field holds 3)
      do_enter();
      wr_en = 1'b1; wr_data = 8'h01; stop_release = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; stop_release = 1'b0;
      run_wait(1'b0, live);
      chk(live == wait_len(2'b11), "R7 same-cycle write uses old", live, wait_len(2'b11));
      do_enter();
      do_release();
      run_wait(1'b0, live);
      chk(live == wait_len(2'b01), "R7 same-cycle write later", live, wait_len(2'b01));

      // R6: stop entry mid-count, restart from zero
      do_enter();
      do_release();
      repeat (5) @(negedge clk);
      do_enter();
      chk(clk_ready == 1'b0, "R6 entry mid-count", clk_ready, 0);
      repeat (12) @(negedge clk);
      chk(clk_ready == 1'b0, "R6 stays down", clk_ready, 0);
      do_release();
      run_wait(1'b0, live);
      chk(live == wait_len(2'b01), "R6 restart from zero", live, wait_len(2'b01));

      // R9: release mid-count does not restart
      do_enter();
      do_release();
      repeat (2) @(negedge clk);
      do_release();
      run_wait(1'b0, live);
      part = 3 + live;
      chk(part == wait_len(2'b01), "R9 release mid-count ignored", part, wait_len(2'b01));

      // R2: bypass for internal and external sources
      for (int s = 1; s < 4; s++) begin
         src_sel = 2'(s);
         do_enter();
         do_release();
         chk(clk_ready == 1'b1, "R2 bypass on release", clk_ready, 1);
      end
      src_sel = 2'b00;

      // R3: reset with non-crystal source, then crystal with code 0
      rst_n = 1'b0; src_sel = 2'b01;
      @(negedge clk);
      chk(clk_ready == 1'b0, "R3 reset clears ready", clk_ready, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(clk_ready == 1'b1, "R3 bypass after reset", clk_ready, 1);
      wr(8'h03);
      rst_n = 1'b0; src_sel = 2'b00; reset_code = 2'b00;
      @(negedge clk);
      rst_n = 1'b1;
      run_wait(1'b0, live);
      chk(live == wait_len(2'b00), "R3 reset ignores register", live, wait_len(2'b00));

      // Random mix
      for (int it = 0; it < 24; it++) begin
         logic [1:0] c;
         logic [1:0] s;
         int         exp;
         c = 2'($urandom % 4);
         s = (($urandom % 3) == 0) ? 2'($urandom % 4) : 2'b00;
         wr({6'($urandom), c});
         src_sel = s;
         do_enter();
         do_release();
         run_wait(1'b1, live);
         exp = (s == 2'b00) ? wait_len(c) : 0;
         chk(live == exp, (s == 2'b00) ? "R1 random wait" : "R2 random bypass", live, exp);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule